// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

The block is a small programmable-logic array with eight output macrocells. Sixteen array signals feed it: eight dedicated inputs and one feedback signal from each macrocell. Each signal is offered to an AND plane as a true column and a complement column, giving 32 columns. Every macrocell owns eight product terms. An OR gate sums those terms, and the macrocell then either registers the sum or passes it straight through. The result goes out through a selectable polarity stage to a bidirectional pin model, which is a drive value plus a drive enable.

A flat configuration vector sets the whole function. It holds the connection bit of every column of every product term, one disable bit per term, two global architecture bits and two local bits per macrocell. The architecture bits choose one of four behaviours for each macrocell:

- **Registered output**: the enable comes from an external pin.
- **Combinational I/O**: the first product term becomes the enable.
- **Combinational output**: the pin is always driven.
- **Dedicated input**: the pin is never driven.

The same mode choice also fixes the feedback source. The vector is loaded before operation and is held steady while the array runs. The registers clear to 0 on a synchronous reset.

Top module: `sop_macro_array`

## Requirements
- R1: Array signal s (0..15) is dedIn[s] for s<8 and the feedback of macrocell s-8 for s>=8. Configuration bit p*32+2s connects the true column of signal s to product term p, and bit p*32+2s+1 connects its complement. Term p=mc*8+t is the t-th term of macrocell mc. A term is the AND of its connected columns, so a term with no connected column is 1, and a term that connects both the true and the complement column of one signal is 0.
- R2: Configuration bit 2048+p set to 1 disables product term p, which then contributes 0 to its macrocell's sum. If all eight terms are disabled, the sum is 0.
- R3: The global architecture field is bits 2113:2112, and the local mode bit of macrocell m is bit 2114+2m. With global field 2'b00, a local mode bit of 1 makes the macrocell a dedicated input (pinOe=0). A local mode bit of 0 makes it a combinational output: pinOe=1 and all eight terms are summed.
- R4: With global field 2'b01, every macrocell is combinational I/O. Term 0 drives pinOe and is excluded from the sum, and the sum is the OR of terms 1..7.
- R5: When global bit 2113 is 1, a macrocell with local mode bit 0 is registered. Its register captures the OR of all eight terms on each rising clock edge, and pinOe equals outEnExt. A macrocell with local mode bit 1 is combinational I/O as in R4.
- R6: The polarity bit of macrocell m is bit 2115+2m. A value of 1 makes pinOut the non-inverted core value, where the core value is the register in registered mode and the sum otherwise. A value of 0 makes pinOut the inverted core value.
- R7: Feedback comes from the macrocell's register in registered mode, and from the macrocell's own pinIn in combinational I/O and dedicated-input modes. In combinational-output mode it comes from the adjacent pin, pinIn[(m+1) mod 8].
- R8: A synchronous reset clears every register to 0, so a registered macrocell with inverting polarity drives pinOut=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the macrocell registers |
| rst | input | 1 | Synchronous reset, active high, clears the registers |
| dedIn | input | 8 | Dedicated array inputs |
| pinIn | input | 8 | Value seen on each macrocell's pin |
| outEnExt | input | 1 | External output enable for registered macrocells, active high |
| cfgVec | input | 2130 | Flat configuration: term columns, term disables, architecture bits |
| pinOut | output | 8 | Drive value of each macrocell pin |
| pinOe | output | 8 | Drive enable of each macrocell pin |

## Verification
Directed patterns isolate single terms:
- A term with no connected column shows the all-ones identity.
- A term that connects both columns of one signal shows the contradiction zero.
- A fully disabled macrocell shows that disabled terms drop out of the sum.
- A term that reads only the feedback column separates own-pin feedback from adjacent-pin feedback.

Sparse random column masks then run in each global architecture setting, with random local modes, polarities and input vectors. A behavioural model is compared on every clock, so term 0 acting as enable, register capture and register feedback, and polarity are each exposed on their own. A reset pulse in the middle of a registered run confirms the clear value.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    OE_NEVER  = 2'd0,
    OE_ALWAYS = 2'd1,
    OE_TERM   = 2'd2,
    OE_PIN    = 2'd3
  } oeSrcE;

  typedef enum logic [1:0] {
    FB_REG = 2'd0,
    FB_OWN = 2'd1,
    FB_ADJ = 2'd2
  } fbSrcE;

  typedef struct packed {
    logic  useReg;
    logic  invert;
    logic  pt0IsOe;
    oeSrcE oeSrc;
    fbSrcE fbSrc;
  } mcCtlT;

endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
#(
  parameter int NUM_MC = 8
) (
  input  logic [1:0]                gArch,
  input  logic [NUM_MC-1:0]         locArch,
  input  logic [NUM_MC-1:0]         locPol,
  output mcCtlT [NUM_MC-1:0]        ctl
);

  always_comb begin
    for (int m = 0; m < NUM_MC; m++) begin
      ctl[m].invert = ~locPol[m];
      if (gArch == 2'b00) begin
        ctl[m].useReg  = 1'b0;
        ctl[m].pt0IsOe = 1'b0;
        if (locArch[m]) begin
          ctl[m].oeSrc = OE_NEVER;
          ctl[m].fbSrc = FB_OWN;
        end else begin
          ctl[m].oeSrc = OE_ALWAYS;
          ctl[m].fbSrc = FB_ADJ;
        end
      end else if (gArch[1] && !locArch[m]) begin
        ctl[m].useReg  = 1'b1;
        ctl[m].pt0IsOe = 1'b0;
        ctl[m].oeSrc   = OE_PIN;
        ctl[m].fbSrc   = FB_REG;
      end else begin
        ctl[m].useReg  = 1'b0;
        ctl[m].pt0IsOe = 1'b1;
        ctl[m].oeSrc   = OE_TERM;
        ctl[m].fbSrc   = FB_OWN;
      end
    end
  end

endmodule

// File: rtl/sop_datapath.sv
module sop_datapath
  import sop_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_MC = 8,
  parameter int NUM_PT = 8
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [NUM_IN-1:0]                        dedIn,
  input  logic [NUM_MC-1:0]                        pinIn,
  input  logic                                     outEnExt,
  input  logic [NUM_MC*NUM_PT*2*(NUM_IN+NUM_MC)-1:0] colMask,
  input  logic [NUM_MC*NUM_PT-1:0]                 ptDis,
  input  mcCtlT [NUM_MC-1:0]                       ctl,
  output logic [NUM_MC-1:0]                        pinOut,
  output logic [NUM_MC-1:0]                        pinOe,
  output logic [NUM_MC-1:0]                        sumVec,
  output logic [NUM_MC-1:0]                        regQ
);

  localparam int NSIG = NUM_IN + NUM_MC;
  localparam int COLS = 2 * NSIG;
  localparam int NPT  = NUM_MC * NUM_PT;

  logic [NUM_MC-1:0] fbVec;
  logic [NSIG-1:0]   sigVec;
  logic [COLS-1:0]   colVal;
  logic [NPT-1:0]    ptVal;
  logic [NUM_MC-1:0] coreVal;

  // feedback selection per macrocell
  always_comb begin
    for (int m = 0; m < NUM_MC; m++) begin
      case (ctl[m].fbSrc)
        FB_REG:  fbVec[m] = regQ[m];
        FB_ADJ:  fbVec[m] = pinIn[(m + 1) % NUM_MC];
        default: fbVec[m] = pinIn[m];
      endcase
    end
  end

  assign sigVec = {fbVec, dedIn};

  // true / complement column pairs
  for (genvar s = 0; s < NSIG; s++) begin : g_col
    assign colVal[2*s]   = sigVec[s];
    assign colVal[2*s+1] = ~sigVec[s];
  end

  // AND plane: unconnected columns read as 1
  for (genvar p = 0; p < NPT; p++) begin : g_term
    assign ptVal[p] = ~ptDis[p] & (&(colVal | ~colMask[p*COLS +: COLS]));
  end

  // OR plane, polarity and enable
  always_comb begin
    for (int m = 0; m < NUM_MC; m++) begin
      logic [NUM_PT-1:0] keep;
      keep       = ctl[m].pt0IsOe ? ~NUM_PT'(1) : '1;
      sumVec[m]  = |(ptVal[m*NUM_PT +: NUM_PT] & keep);
      coreVal[m] = ctl[m].useReg ? regQ[m] : sumVec[m];
      pinOut[m]  = coreVal[m] ^ ctl[m].invert;
      case (ctl[m].oeSrc)
        OE_NEVER:  pinOe[m] = 1'b0;
        OE_ALWAYS: pinOe[m] = 1'b1;
        OE_TERM:   pinOe[m] = ptVal[m*NUM_PT];
        default:   pinOe[m] = outEnExt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) regQ <= '0;
    else     regQ <= sumVec;
  end

endmodule

// File: rtl/sop_macro_array.sv
module sop_macro_array
  import sop_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_MC = 8,
  parameter int NUM_PT = 8,
  localparam int NSIG  = NUM_IN + NUM_MC,
  localparam int COLS  = 2 * NSIG,
  localparam int NPT   = NUM_MC * NUM_PT,
  localparam int DIS_BASE  = NPT * COLS,
  localparam int ARCH_BASE = DIS_BASE + NPT,
  localparam int CFG_W = ARCH_BASE + 2 + 2 * NUM_MC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] dedIn,
  input  logic [NUM_MC-1:0] pinIn,
  input  logic              outEnExt,
  input  logic [CFG_W-1:0]  cfgVec,
  output logic [NUM_MC-1:0] pinOut,
  output logic [NUM_MC-1:0] pinOe
);

  logic [1:0]        gArch;
  logic [NUM_MC-1:0] locArch, locPol, sumVec, regQ;
  mcCtlT [NUM_MC-1:0] ctl;

  assign gArch = cfgVec[ARCH_BASE +: 2];
  for (genvar m = 0; m < NUM_MC; m++) begin : g_loc
    assign locArch[m] = cfgVec[ARCH_BASE + 2 + 2*m];
    assign locPol[m]  = cfgVec[ARCH_BASE + 3 + 2*m];
  end

  sop_ctrl #(.NUM_MC(NUM_MC)) u_ctrl (
    .gArch   (gArch),
    .locArch (locArch),
    .locPol  (locPol),
    .ctl     (ctl)
  );

  sop_datapath #(.NUM_IN(NUM_IN), .NUM_MC(NUM_MC), .NUM_PT(NUM_PT)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dedIn    (dedIn),
    .pinIn    (pinIn),
    .outEnExt (outEnExt),
    .colMask  (cfgVec[DIS_BASE-1:0]),
    .ptDis    (cfgVec[ARCH_BASE-1:DIS_BASE]),
    .ctl      (ctl),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .sumVec   (sumVec),
    .regQ     (regQ)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> regQ == '0); // R8
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> regQ == $past(sumVec)); // R5

  for (genvar m = 0; m < NUM_MC; m++) begin : g_chk
    AST_DEDIN_FLOAT: assert property (@(posedge clk) disable iff (rst)
      (gArch == 2'b00 && locArch[m]) |-> !pinOe[m]); // R3
    AST_SIMPLE_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (gArch == 2'b00 && !locArch[m]) |-> pinOe[m]); // R3
    AST_REG_OE: assert property (@(posedge clk) disable iff (rst)
      (gArch[1] && !locArch[m]) |-> pinOe[m] == outEnExt); // R5
    AST_REG_POLARITY: assert property (@(posedge clk) disable iff (rst)
      (gArch[1] && !locArch[m]) |-> pinOut[m] == (regQ[m] ^ ~locPol[m])); // R6
    AST_ALL_TERMS_OFF: assert property (@(posedge clk) disable iff (rst)
      (gArch == 2'b00 && !locArch[m] && (&cfgVec[DIS_BASE + m*NUM_PT +: NUM_PT]))
      |-> pinOut[m] == ~locPol[m]); // R2
  end

endmodule

// File: tb/sop_macro_array_tb.sv
module sop_macro_array_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN = 8;
  localparam int NUM_MC = 8;
  localparam int NUM_PT = 8;
  localparam int NSIG = NUM_IN + NUM_MC;
  localparam int COLS = 2 * NSIG;
  localparam int NPT = NUM_MC * NUM_PT;
  localparam int DIS_BASE = NPT * COLS;
  localparam int ARCH_BASE = DIS_BASE + NPT;
  localparam int CFG_W = ARCH_BASE + 2 + 2 * NUM_MC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_IN-1:0] dedIn = '0;
  logic [NUM_MC-1:0] pinIn = '0;
  logic outEnExt = 1'b1;
  logic [CFG_W-1:0] cfgVec;
  logic [NUM_MC-1:0] pinOut, pinOe;

  logic [COLS-1:0]   mask [NPT];
  logic              dis  [NPT];
  logic [1:0]        gArch = 2'b10;
  logic [NUM_MC-1:0] locA = '0;
  logic [NUM_MC-1:0] locP = '0;
  logic [NUM_MC-1:0] refQ = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    cfgVec = '0;
    for (int p = 0; p < NPT; p++) begin
      cfgVec[p*COLS +: COLS] = mask[p];
      cfgVec[DIS_BASE + p] = dis[p];
    end
    cfgVec[ARCH_BASE +: 2] = gArch;
    for (int m = 0; m < NUM_MC; m++) begin
      cfgVec[ARCH_BASE + 2 + 2*m] = locA[m];
      cfgVec[ARCH_BASE + 3 + 2*m] = locP[m];
    end
  end

  sop_macro_array u_dut (
    .clk(clk), .rst(rst), .dedIn(dedIn), .pinIn(pinIn), .outEnExt(outEnExt),
    .cfgVec(cfgVec), .pinOut(pinOut), .pinOe(pinOe)
  );

  // 0 dedicated input, 1 comb output, 2 comb I/O, 3 registered
  function automatic int modeOf(int m);
    if (gArch == 2'b00) return locA[m] ? 0 : 1;
    if (gArch == 2'b01) return 2;
    return locA[m] ? 2 : 3;
  endfunction

  function automatic logic termEval(int p, logic [NSIG-1:0] sig);
    if (dis[p]) return 1'b0;
    for (int s = 0; s < NSIG; s++) begin
      if (mask[p][2*s] && !sig[s]) return 1'b0;
      if (mask[p][2*s+1] && sig[s]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic refModel(output logic [NUM_MC-1:0] eOut, eOe, eSum);
    logic [NUM_MC-1:0] fb;
    logic [NSIG-1:0] sig;
    for (int m = 0; m < NUM_MC; m++) begin
      case (modeOf(m))
        3: fb[m] = refQ[m];
        1: fb[m] = pinIn[(m + 1) % NUM_MC];
        default: fb[m] = pinIn[m];
      endcase
    end
    sig = {fb, dedIn};
    for (int m = 0; m < NUM_MC; m++) begin
      logic sum, oeT, core;
      int md;
      md = modeOf(m);
      sum = 1'b0;
      oeT = 1'b0;
      for (int t = 0; t < NUM_PT; t++) begin
        logic pv;
        pv = termEval(m*NUM_PT + t, sig);
        if (t == 0 && md == 2) oeT = pv;
        else sum = sum | pv;
      end
      eSum[m] = sum;
      core = (md == 3) ? refQ[m] : sum;
      eOut[m] = locP[m] ? core : ~core;
      case (md)
        0: eOe[m] = 1'b0;
        1: eOe[m] = 1'b1;
        2: eOe[m] = oeT;
        default: eOe[m] = outEnExt;
      endcase
    end
  endtask

  task automatic check(string tag, logic [NUM_MC-1:0] act, logic [NUM_MC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %b exp %b", tag, act, exp);
    end
  endtask

  // inputs already driven after a falling edge; compare, then advance model
  task automatic cycle(string tag);
    logic [NUM_MC-1:0] eOut, eOe, eSum;
    #(CLK_PERIOD/4);
    refModel(eOut, eOe, eSum);
    check({tag, " pinOut"}, pinOut, eOut);
    check({tag, " pinOe"}, pinOe, eOe);
    @(posedge clk);
    refQ = rst ? '0 : eSum;
    @(negedge clk);
  endtask

  task automatic loadRandomCfg(logic [1:0] ga);
    gArch = ga;
    locA = NUM_MC'($urandom);
    locP = NUM_MC'($urandom);
    for (int p = 0; p < NPT; p++) begin
      mask[p] = COLS'($urandom & $urandom & $urandom);
      dis[p] = ($urandom % 5) == 0;
    end
  endtask

  task automatic resetPulse();
    rst = 1'b1;
    @(posedge clk);
    refQ = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic randomRun(string tag, int n);
    for (int i = 0; i < n; i++) begin
      dedIn = NUM_IN'($urandom);
      pinIn = NUM_MC'($urandom);
      outEnExt = 1'($urandom);
      cycle(tag);
    end
  endtask

  initial begin
    for (int p = 0; p < NPT; p++) begin
      mask[p] = '0;
      dis[p] = 1'b0;
    end
    // R8: registered, inverting, reset held
    gArch = 2'b10; locA = '0; locP = '0;
    @(negedge clk); @(negedge clk);
    refQ = '0;
    #(CLK_PERIOD/4);
    check("R8 reset pinOut", pinOut, '1);
    check("R8 reset pinOe", pinOe, '1);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2 / R7 directed, simple mode, non-inverting
    rst = 1'b1;
    gArch = 2'b00; locA = '0; locP = '1;
    for (int p = 0; p < NPT; p++) begin
      dis[p] = 1'b1;
      mask[p] = '0;
    end
    dis[0] = 1'b0;                              // mc0 term0: no columns
    dis[8] = 1'b0; mask[8] = 32'h3;             // mc1: both columns of signal 0
    dis[16] = 1'b0; mask[16] = 32'h1;           // mc2: dedIn[0] true
    locP[3] = 1'b0;                             // mc3: all terms disabled, inverted
    dis[32] = 1'b0; mask[32] = 32'h1 << 24;     // mc4: feedback column of signal 12
    @(negedge clk);
    rst = 1'b0;
    dedIn = 8'h01; pinIn = 8'h20;
    #(CLK_PERIOD/4);
    check("R1 empty term", NUM_MC'(pinOut[0]), 8'h01);
    check("R1 contradiction", NUM_MC'(pinOut[1]), 8'h00);
    check("R1 true column", NUM_MC'(pinOut[2]), 8'h01);
    check("R2 all disabled", NUM_MC'(pinOut[3]), 8'h01);
    check("R7 adjacent fb", NUM_MC'(pinOut[4]), 8'h01);
    @(negedge clk);
    dedIn = 8'h00; pinIn = 8'h10;
    #(CLK_PERIOD/4);
    check("R1 true column low", NUM_MC'(pinOut[2]), 8'h00);
    check("R7 own pin ignored", NUM_MC'(pinOut[4]), 8'h00);
    @(negedge clk);
    cycle("R1");
    cycle("R2");

    // R7 own-pin feedback in comb I/O
    rst = 1'b1; gArch = 2'b01; locA = '0; locP = '1;
    @(negedge clk); rst = 1'b0;
    dedIn = '0; pinIn = 8'h10;
    #(CLK_PERIOD/4);
    check("R7 own fb oe", NUM_MC'(pinOe[4]), 8'h01);
    @(negedge clk);
    cycle("R7");

    // random runs per architecture
    loadRandomCfg(2'b00); resetPulse(); randomRun("R3", 250);
    loadRandomCfg(2'b01); resetPulse(); randomRun("R4", 250);
    loadRandomCfg(2'b10); resetPulse(); randomRun("R5", 250);
    loadRandomCfg(2'b11); resetPulse(); randomRun("R6", 250);

    // R8 mid-run reset pulse on registered cells
    loadRandomCfg(2'b10); locA = '0; resetPulse(); randomRun("R5", 40);
    rst = 1'b1;
    cycle("R8");
    rst = 1'b0;
    randomRun("R8", 40);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule